// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block gathers up to eight interrupt sources and presents one interrupt line to a processor. Each source is synchronized, and a rising edge latches a pending flag. A software-written mask filters the pending flags, and a fixed-priority resolver finds the best candidate. The line `int_o` rises only when that candidate outranks every level the processor is already servicing, so service nests by priority.

The processor answers with two acknowledge pulses on `inta_i`. The first pulse freezes the choice, marks that level as in service and clears its pending flag. The second pulse returns a vector: a programmable 5-bit base in the upper bits and the 3-bit level number in the lower bits. A level stays in service until software writes a non-specific end-of-service command, which retires the highest-priority level in service.

A small write/read port carries commands, the mask and the vector base. The vector leaves as a one-cycle strobe (`vec_valid` with `vec_data`) and has no back-pressure, because the processor sets the pace through its acknowledge pulses. The port and the acknowledge are plain control pins.

Top module: `pic_core`

## Requirements
- R1: After reset, `int_o` and `vec_valid` are 0, the mask reads 0x00 and the vector base is 0.
- R2: A rising edge on an unmasked `irq_in[i]` latches a pending flag. With nothing in service, `int_o` is 1 from the third clock edge after the input change.
- R3: A masked input still latches its pending flag but never raises `int_o` and is never granted. After the mask bit is cleared, that kept flag raises `int_o`.
- R4: Masking a higher-priority level does not block a lower unmasked level, which is then granted.
- R5: Priority is fixed: level 0 is highest and level 7 is lowest. Among pending unmasked levels, the lowest index is granted.
- R6: The first `inta_i` pulse drops `int_o` in the following cycle. The second pulse makes `vec_valid` 1 for exactly one cycle, with `vec_data` = {base[4:0], level[2:0]}.
- R7: A level in service blocks `int_o` for pending levels of equal or lower priority. A higher-priority pending level raises `int_o`, which gives nested service.
- R8: A write with `bus_addr`=0, data bit 4 = 0 and data bit 5 = 1 (for example 0x20) clears only the highest-priority in-service level.
- R9: If an input falls before it is acknowledged, its pending flag clears once the synchronizer sees the fall (three edges), and `int_o` drops.
- R10: A write with `bus_addr`=0 and data bit 4 = 1 (for example 0x10) clears the pending, in-service and mask state. The next write with `bus_addr`=1 loads the vector base from data bits 7:3 and leaves the mask unchanged.
- R11: Outside initialization, a write with `bus_addr`=1 loads the mask (a 1 masks the level). With `bus_addr`=1, `bus_rdata` returns the mask.
- R12: An end-of-service write and a first acknowledge pulse in the same cycle both take effect. The old top in-service level is cleared and the newly granted level is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Asynchronous interrupt sources, edge triggered |
| bus_wr | input | 1 | Write strobe for the command port |
| bus_addr | input | 1 | Register select: 0 selects command, 1 selects mask or base |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Mask when `bus_addr`=1, otherwise 0 |
| int_o | output | 1 | Interrupt request to the processor |
| inta_i | input | 1 | Acknowledge pulse from the processor, one cycle per pulse |
| vec_valid | output | 1 | Vector strobe after the second acknowledge |
| vec_data | output | 8 | Vector: base and level |

## Verification
Two events can land in the same clock edge: an end-of-service write and the first acknowledge pulse. Both change the in-service set. The bench brings this about by nesting a level-1 request over level 4 in service, then driving the 0x20 write and `inta_i` in the same cycle. The vector must name level 1. The removal of level 4 shows at the ports: after one more end-of-service command, a new level-6 request must raise `int_o`, which could not happen if level 4 were still in service.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic {
    ACK_IDLE = 1'b0,
    ACK_VEC  = 1'b1
  } ack_state_e;

  localparam int CMD_INIT_BIT = 4;
  localparam int CMD_EOI_BIT  = 5;
endpackage

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
  parameter int N           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_all,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] irr,
  output logic [N-1:0] lvl
);
  logic [N-1:0] rise;

  for (genvar i = 0; i < N; i++) begin : g_src
    logic [SYNC_STAGES:0] sh;

    always_ff @(posedge clk) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[SYNC_STAGES-1:0], irq_in[i]};
    end

    assign lvl[i]  = sh[SYNC_STAGES-1];
    assign rise[i] = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];

    always_ff @(posedge clk) begin
      if (!rst_n || clr_all) irr[i] <= 1'b0;
      else if (rise[i])      irr[i] <= 1'b1;
      else if (!lvl[i])      irr[i] <= 1'b0;
      else if (ack_clr[i])   irr[i] <= 1'b0;
    end
  end

  // R2
  irr_set_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irr & ~$past(irr)) & ~$past(rise)) == '0);

  // R9
  fall_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irr & ~$past(lvl)) == '0);
endmodule

// File: rtl/pic_prio_resolver.sv
module pic_prio_resolver #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  irr,
  input  logic [N-1:0]  mask,
  input  logic [N-1:0]  isr,
  output logic          req_any,
  output logic [IW-1:0] req_idx,
  output logic          isr_any,
  output logic [IW-1:0] isr_idx,
  output logic          int_req
);
  logic [N-1:0] pend;

  assign pend = irr & ~mask;

  always_comb begin
    req_any = 1'b0;
    req_idx = '0;
    isr_any = 1'b0;
    isr_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        req_any = 1'b1;
        req_idx = IW'(i);
      end
      if (isr[i]) begin
        isr_any = 1'b1;
        isr_idx = IW'(i);
      end
    end
  end

  assign int_req = req_any && (!isr_any || (req_idx < isr_idx));
endmodule

// File: rtl/pic_cmd_regs.sv
module pic_cmd_regs
  import pic_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int BW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic [N-1:0]  mask,
  output logic [BW-1:0] base,
  output logic          init_pulse,
  output logic          eoi_pulse
);
  logic init_wait;

  assign init_pulse = wr_en && !addr && wr_data[CMD_INIT_BIT];
  assign eoi_pulse  = wr_en && !addr && !wr_data[CMD_INIT_BIT] && wr_data[CMD_EOI_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask      <= '0;
      base      <= '0;
      init_wait <= 1'b0;
    end else if (init_pulse) begin
      mask      <= '0;
      init_wait <= 1'b1;
    end else if (wr_en && addr) begin
      if (init_wait) begin
        base      <= wr_data[DW-1 -: BW];
        init_wait <= 1'b0;
      end else begin
        mask <= wr_data[N-1:0];
      end
    end
  end

  assign rd_data = addr ? DW'(mask) : '0;

  // R10
  init_mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_pulse |=> (mask == '0));

  // R10
  base_keeps_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && init_wait) |=> $stable(mask));
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int DATA_W  = 8,
  parameter int BASE_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              int_o,
  input  logic              inta_i,
  output logic              vec_valid,
  output logic [DATA_W-1:0] vec_data
);
  localparam int IDX_W = $clog2(NUM_IRQ);

  logic [NUM_IRQ-1:0] irr, lvl, mask, isr, set_vec, eoi_vec;
  logic [BASE_W-1:0]  base;
  logic               init_pulse, eoi_pulse;
  logic               req_any, isr_any, int_req, ack_take;
  logic [IDX_W-1:0]   req_idx, isr_idx, grant_idx;
  ack_state_e         state;

  pic_cmd_regs #(.N(NUM_IRQ), .DW(DATA_W), .BW(BASE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wr_data(bus_wdata), .rd_data(bus_rdata), .mask(mask), .base(base),
    .init_pulse(init_pulse), .eoi_pulse(eoi_pulse)
  );

  pic_req_latch #(.N(NUM_IRQ), .SYNC_STAGES(2)) u_req (
    .clk(clk), .rst_n(rst_n), .clr_all(init_pulse), .irq_in(irq_in),
    .ack_clr(set_vec), .irr(irr), .lvl(lvl)
  );

  pic_prio_resolver #(.N(NUM_IRQ), .IW(IDX_W)) u_prio (
    .irr(irr), .mask(mask), .isr(isr), .req_any(req_any), .req_idx(req_idx),
    .isr_any(isr_any), .isr_idx(isr_idx), .int_req(int_req)
  );

  assign ack_take = inta_i && (state == ACK_IDLE);
  assign set_vec  = (ack_take && req_any) ? (NUM_IRQ'(1) << req_idx) : '0;
  assign eoi_vec  = (eoi_pulse && isr_any) ? (NUM_IRQ'(1) << isr_idx) : '0;
  assign int_o    = int_req && (state == ACK_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n || init_pulse) isr <= '0;
    else                      isr <= (isr & ~eoi_vec) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || init_pulse) begin
      state     <= ACK_IDLE;
      grant_idx <= '0;
      vec_valid <= 1'b0;
      vec_data  <= '0;
    end else begin
      vec_valid <= 1'b0;
      if (ack_take) begin
        state     <= ACK_VEC;
        grant_idx <= req_any ? req_idx : IDX_W'(NUM_IRQ - 1);
      end else if (inta_i && state == ACK_VEC) begin
        state     <= ACK_IDLE;
        vec_valid <= 1'b1;
        vec_data  <= DATA_W'({base, grant_idx});
      end
    end
  end

  // R3
  mask_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && req_any) |-> !mask[req_idx]);

  // R5
  prio_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_any |-> ((irr & ~mask & ((NUM_IRQ'(1) << req_idx) - NUM_IRQ'(1))) == '0));

  // R6
  int_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> !int_o);

  // R6
  vec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);

  // R8
  eoi_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_pulse && !ack_take) |=>
      ($countones(isr) + ((|$past(isr)) ? 1 : 0) == $countones($past(isr))));

  // R10
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_pulse |=> (isr == '0 && irr == '0));
endmodule

// File: tb/pic_core_bench.sv
`timescale 1ns/1ps
module pic_core_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_in;
  logic       bus_wr, bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       int_o, inta_i, vec_valid;
  logic [7:0] vec_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  pic_core u_pic_core (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .int_o(int_o), .inta_i(inta_i), .vec_valid(vec_valid), .vec_data(vec_data)
  );

  localparam logic [7:0] BASE = 8'hA8;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = '0;
  endtask

  task automatic read_mask(input string req, input logic [7:0] exp);
    @(negedge clk);
    bus_addr = 1'b1;
    #1 chk(req, bus_rdata, exp);
    bus_addr = 1'b0;
  endtask

  task automatic inta_pulse();
    @(negedge clk);
    inta_i = 1'b1;
    @(negedge clk);
    inta_i = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic ack_expect(input string req, input logic [7:0] vec);
    inta_pulse();
    chk({req, " int low after first ack"}, 8'(int_o), 8'h0);
    inta_pulse();
    chk({req, " vec_valid"}, 8'(vec_valid), 8'h1);
    chk({req, " vec_data"}, vec_data, vec);
    @(negedge clk);
    chk({req, " vec_valid one cycle"}, 8'(vec_valid), 8'h0);
  endtask

  task automatic t_reset();
    chk("R1 int_o", 8'(int_o), 8'h0);
    chk("R1 vec_valid", 8'(vec_valid), 8'h0);
    read_mask("R1 mask", 8'h00);
  endtask

  task automatic t_init_base();
    bus_write(1'b1, 8'h0F);
    read_mask("R11 mask write", 8'h0F);
    bus_write(1'b0, 8'h10);
    read_mask("R10 init clears mask", 8'h00);
    bus_write(1'b1, BASE);
    read_mask("R10 base write keeps mask", 8'h00);
  endtask

  task automatic t_single();
    irq_in[2] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R2 int not yet", 8'(int_o), 8'h0);
    @(negedge clk);
    chk("R2 int raised", 8'(int_o), 8'h1);
    ack_expect("R6", BASE | 8'd2);
    bus_write(1'b0, 8'h20);
    irq_in[2] = 1'b0;
    settle();
  endtask

  task automatic t_priority();
    irq_in[5] = 1'b1; irq_in[2] = 1'b1;
    settle();
    chk("R5 int raised", 8'(int_o), 8'h1);
    ack_expect("R5", BASE | 8'd2);
    chk("R7 lower blocked", 8'(int_o), 8'h0);
    irq_in[1] = 1'b1;
    settle();
    chk("R7 higher nests", 8'(int_o), 8'h1);
    ack_expect("R7", BASE | 8'd1);
    bus_write(1'b0, 8'h20);
    chk("R8 level 2 still blocks", 8'(int_o), 8'h0);
    bus_write(1'b0, 8'h20);
    chk("R8 all retired", 8'(int_o), 8'h1);
    ack_expect("R8", BASE | 8'd5);
    bus_write(1'b0, 8'h20);
    irq_in = '0;
    settle();
  endtask

  task automatic t_mask();
    bus_write(1'b1, 8'h01);
    read_mask("R11 mask readback", 8'h01);
    irq_in[0] = 1'b1; irq_in[3] = 1'b1;
    settle();
    chk("R4 lower unmasked raises", 8'(int_o), 8'h1);
    ack_expect("R4", BASE | 8'd3);
    bus_write(1'b0, 8'h20);
    chk("R3 masked silent", 8'(int_o), 8'h0);
    bus_write(1'b1, 8'h00);
    chk("R3 kept flag raises", 8'(int_o), 8'h1);
    ack_expect("R3", BASE | 8'd0);
    bus_write(1'b0, 8'h20);
    irq_in = '0;
    settle();
  endtask

  task automatic t_fall();
    irq_in[6] = 1'b1;
    settle();
    chk("R9 raised", 8'(int_o), 8'h1);
    irq_in[6] = 1'b0;
    settle();
    chk("R9 fall clears", 8'(int_o), 8'h0);
  endtask

  task automatic t_collide();
    irq_in[4] = 1'b1;
    settle();
    ack_expect("R12 setup", BASE | 8'd4);
    irq_in[1] = 1'b1;
    settle();
    chk("R12 nest raised", 8'(int_o), 8'h1);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = 8'h20; inta_i = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; inta_i = 1'b0;
    chk("R12 int low", 8'(int_o), 8'h0);
    inta_pulse();
    chk("R12 vector", vec_data, BASE | 8'd1);
    bus_write(1'b0, 8'h20);
    irq_in[6] = 1'b1;
    settle();
    chk("R12 level 4 retired", 8'(int_o), 8'h1);
    ack_expect("R12", BASE | 8'd6);
    bus_write(1'b0, 8'h20);
    irq_in = '0;
    settle();
  endtask

  task automatic t_init_clear();
    irq_in[3] = 1'b1;
    settle();
    chk("R10 pending", 8'(int_o), 8'h1);
    bus_write(1'b0, 8'h10);
    chk("R10 init clears pending", 8'(int_o), 8'h0);
    bus_write(1'b1, BASE);
    settle();
    chk("R10 stays clear", 8'(int_o), 8'h0);
    irq_in = '0;
    settle();
  endtask

  initial begin
    rst_n = 1'b0; irq_in = '0; bus_wr = 1'b0; bus_addr = 1'b0;
    bus_wdata = '0; inta_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_init_base();
    t_single();
    t_priority();
    t_mask();
    t_fall();
    t_collide();
    t_init_clear();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule